// File: doc/BRIEF.md
# Host Link Handshake Timeout Supervisor

This block watches the timing of a request/response exchange between a modem core and a host microcontroller on a serial link. It takes single-cycle event strobes and a 1 ms timebase tick. It runs one shared down-counter, which is reloaded with the wait limit of each handshake phase as that phase begins. The phases cover four cases: the host drops its request line and the status message must start; a status message has finished and a start-of-frame character must follow; a transmission has ended and the far side's ACK or NAK must arrive; a reception has ended and a short hold must pass before the next frame goes out.

When a limit runs out, the block raises a one-cycle pulse on that phase's own timeout output and returns to idle. An ACK gives an `ack_ok` pulse. A NAK gives a `retry_req` pulse. When the hold after a reception has elapsed, the block gives a `send_ok` pulse. A request strobe that arrives while a phase is active is dropped and counted in a saturating error counter. Byte framing, checksums and data movement are handled elsewhere.

Top module: `hs_timeout_sup`

## Requirements
- R1: In idle, `req_low` starts a 20-tick status window. If `status_begin` does not arrive, `to_poll` pulses one cycle after the clock edge that samples the 20th tick, and the block returns to idle.
- R2: While the status message is in flight (between `status_begin` and `status_end`), the window timer ignores ticks. `status_end` opens a 200-tick window for `stx_seen`. `stx_seen` closes the window silently and returns the block to idle. If `stx_seen` does not arrive, `to_stx` pulses after the 200th tick.
- R3: In idle, `tx_end` opens a 40-tick acknowledge window. If no ACK or NAK arrives, `to_ack` pulses after the 40th tick.
- R4: In the acknowledge window, `ack_seen` gives an `ack_ok` pulse and `nak_seen` gives a `retry_req` pulse. If both arrive in the same cycle, ACK wins. Either one returns the block to idle, and no timer keeps running.
- R5: In idle, `rx_end` starts a 5-tick hold. `send_ok` pulses after the 5th tick.
- R6: An event strobe sampled on the same edge as the expiring tick counts as on time. No timeout pulse follows.
- R7: `req_low` outside idle is ignored and does not restart the running window. It adds one to `err_cnt` (8 bits), which holds at 255.
- R8: In idle, if several events arrive together, `req_low` has priority over `tx_end`, which has priority over `rx_end`. In idle, `status_begin`, `status_end`, `stx_seen`, `ack_seen` and `nak_seen` have no effect.
- R9: During and after reset, all pulse outputs are 0, `err_cnt` is 0 and the block is idle.
- R10: Each pulse output stays high for exactly one cycle, and at most one pulse output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1ms | input | 1 | One-cycle timebase strobe, once per millisecond |
| req_low | input | 1 | Host request line was pulled low |
| status_begin | input | 1 | Status message transmission started |
| status_end | input | 1 | Status message transmission finished |
| stx_seen | input | 1 | Start-of-frame character received |
| tx_end | input | 1 | A frame transmission finished |
| ack_seen | input | 1 | ACK character received |
| nak_seen | input | 1 | NAK character received |
| rx_end | input | 1 | A frame reception finished |
| to_poll | output | 1 | Status-start timeout pulse |
| to_stx | output | 1 | Start-of-frame timeout pulse |
| to_ack | output | 1 | Acknowledge timeout pulse |
| ack_ok | output | 1 | ACK received in time |
| retry_req | output | 1 | NAK received, retransmission wanted |
| send_ok | output | 1 | Hold after reception elapsed; next frame may go |
| err_cnt | output | 8 | Saturating count of requests made while busy |

## Verification
Every result is registered once. A timeout or grant appears in the cycle after the clock edge that samples the completing tick. `ack_ok` and `retry_req` appear in the cycle after the edge that samples the character strobe. `err_cnt` changes one edge after the offending request. The bench drives inputs on the falling edge and reads the outputs 1 ns after the following rising edge, so each check looks at exactly the cycle in which the result is due. A sticky record of every pulse shows that nothing fired one tick early.

// File: rtl/hs_sup_pkg.sv
package hs_sup_pkg;

  typedef enum logic [2:0] {
    PH_IDLE        = 3'd0,
    PH_WAIT_STATUS = 3'd1,
    PH_WAIT_STX    = 3'd2,
    PH_WAIT_ACK    = 3'd3,
    PH_HOLDOFF     = 3'd4
  } phase_t;

  // bit positions inside the registered pulse vector
  localparam int PB_POLL  = 0;
  localparam int PB_STX   = 1;
  localparam int PB_ACK   = 2;
  localparam int PB_OK    = 3;
  localparam int PB_RETRY = 4;
  localparam int PB_SEND  = 5;
  localparam int NPULSE   = 6;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // window length (in ticks) that belongs to a phase
  function automatic int phase_limit(input phase_t ph, input int poll, input int stx,
                                     input int ack, input int wbc);
    case (ph)
      PH_WAIT_STATUS: return poll;
      PH_WAIT_STX:    return stx;
      PH_WAIT_ACK:    return ack;
      PH_HOLDOFF:     return wbc;
      default:        return 0;
    endcase
  endfunction

endpackage

// File: rtl/hs_phase_timer.sv
module hs_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  // the limit-th tick since the load is the one that expires
  assign expire = run && tick && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (run && tick && (cnt_q > CNT_W'(1)))
      cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/hs_sat_counter.sv
module hs_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (inc && (cnt != '1))
      cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/hs_timeout_sup.sv
module hs_timeout_sup
  import hs_sup_pkg::*;
#(
  parameter int POLL_TICKS = 20,
  parameter int STX_TICKS  = 200,
  parameter int ACK_TICKS  = 40,
  parameter int WBC_TICKS  = 5,
  parameter int ERR_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1ms,
  input  logic             req_low,
  input  logic             status_begin,
  input  logic             status_end,
  input  logic             stx_seen,
  input  logic             tx_end,
  input  logic             ack_seen,
  input  logic             nak_seen,
  input  logic             rx_end,
  output logic             to_poll,
  output logic             to_stx,
  output logic             to_ack,
  output logic             ack_ok,
  output logic             retry_req,
  output logic             send_ok,
  output logic [ERR_W-1:0] err_cnt
);
  localparam int MAX_TICKS = max4(POLL_TICKS, STX_TICKS, ACK_TICKS, WBC_TICKS);
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  phase_t              state_q, state_d;
  logic                busy_q, busy_d;
  logic                tmr_load, tmr_run, tmr_expire;
  logic [CNT_W-1:0]    tmr_lval;
  logic [NPULSE-1:0]   pulse_d, pulse_q;
  logic                req_err;

  assign tmr_run = (state_q != PH_IDLE) && !((state_q == PH_WAIT_STATUS) && busy_q);
  assign req_err = req_low && (state_q != PH_IDLE);

  hs_phase_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_lval),
    .run      (tmr_run),
    .tick     (tick_1ms),
    .expire   (tmr_expire)
  );

  hs_sat_counter #(.W(ERR_W)) err_i (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (req_err),
    .cnt   (err_cnt)
  );

  always_comb begin
    state_d  = state_q;
    busy_d   = busy_q;
    tmr_load = 1'b0;
    pulse_d  = '0;
    case (state_q)
      PH_IDLE: begin
        busy_d = 1'b0;
        if (req_low)     state_d = PH_WAIT_STATUS;
        else if (tx_end) state_d = PH_WAIT_ACK;
        else if (rx_end) state_d = PH_HOLDOFF;
        tmr_load = (state_d != PH_IDLE);
      end
      PH_WAIT_STATUS: begin
        if (status_end) begin
          state_d  = PH_WAIT_STX;
          busy_d   = 1'b0;
          tmr_load = 1'b1;
        end else if (status_begin) begin
          busy_d = 1'b1;
        end else if (tmr_expire) begin
          state_d          = PH_IDLE;
          pulse_d[PB_POLL] = 1'b1;
        end
      end
      PH_WAIT_STX: begin
        if (stx_seen) begin
          state_d = PH_IDLE;
        end else if (tmr_expire) begin
          state_d         = PH_IDLE;
          pulse_d[PB_STX] = 1'b1;
        end
      end
      PH_WAIT_ACK: begin
        if (ack_seen) begin
          state_d        = PH_IDLE;
          pulse_d[PB_OK] = 1'b1;
        end else if (nak_seen) begin
          state_d           = PH_IDLE;
          pulse_d[PB_RETRY] = 1'b1;
        end else if (tmr_expire) begin
          state_d         = PH_IDLE;
          pulse_d[PB_ACK] = 1'b1;
        end
      end
      PH_HOLDOFF: begin
        if (tmr_expire) begin
          state_d          = PH_IDLE;
          pulse_d[PB_SEND] = 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
    tmr_lval = CNT_W'(phase_limit(state_d, POLL_TICKS, STX_TICKS, ACK_TICKS, WBC_TICKS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      busy_q  <= 1'b0;
      pulse_q <= '0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
      pulse_q <= pulse_d;
    end
  end

  assign to_poll   = pulse_q[PB_POLL];
  assign to_stx    = pulse_q[PB_STX];
  assign to_ack    = pulse_q[PB_ACK];
  assign ack_ok    = pulse_q[PB_OK];
  assign retry_req = pulse_q[PB_RETRY];
  assign send_ok   = pulse_q[PB_SEND];
endmodule

// File: rtl/hs_timeout_sup_chk.sv
module hs_timeout_sup_chk
  import hs_sup_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stx_seen,
  input logic             ack_seen,
  input logic             nak_seen,
  input logic             req_low,
  input logic             to_poll,
  input logic             to_stx,
  input logic             to_ack,
  input logic             ack_ok,
  input logic             retry_req,
  input logic             send_ok,
  input logic [ERR_W-1:0] err_cnt,
  input phase_t           state
);
  logic [5:0] pv;
  assign pv = {send_ok, retry_req, ack_ok, to_ack, to_stx, to_poll};

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pv)); // R10
  AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (pv != '0) |-> (state == PH_IDLE)); // R10
  AST_POLL_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n) to_poll |-> ($past(state) == PH_WAIT_STATUS)); // R1
  AST_STX_LATE: assert property (@(posedge clk) disable iff (!rst_n) to_stx |-> ($past(state) == PH_WAIT_STX && !$past(stx_seen))); // R2
  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) ack_ok |-> ($past(ack_seen) && $past(state) == PH_WAIT_ACK)); // R4
  AST_RETRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) retry_req |-> ($past(nak_seen) && !$past(ack_seen))); // R4
  AST_SEND_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) send_ok |-> ($past(state) == PH_HOLDOFF)); // R5
  AST_ERR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n) (err_cnt == '1) |=> (err_cnt == '1)); // R7
  AST_IDLE_REQ_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n) (state == PH_IDLE && req_low) |=> $stable(err_cnt)); // R7
endmodule

bind hs_timeout_sup hs_timeout_sup_chk #(.ERR_W(ERR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .stx_seen  (stx_seen),
  .ack_seen  (ack_seen),
  .nak_seen  (nak_seen),
  .req_low   (req_low),
  .to_poll   (to_poll),
  .to_stx    (to_stx),
  .to_ack    (to_ack),
  .ack_ok    (ack_ok),
  .retry_req (retry_req),
  .send_ok   (send_ok),
  .err_cnt   (err_cnt),
  .state     (state_q)
);

// File: tb/hs_timeout_sup_tb.sv
module hs_timeout_sup_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1ms = 1'b0;
  logic req_low = 1'b0, status_begin = 1'b0, status_end = 1'b0, stx_seen = 1'b0;
  logic tx_end = 1'b0, ack_seen = 1'b0, nak_seen = 1'b0, rx_end = 1'b0;
  logic to_poll, to_stx, to_ack, ack_ok, retry_req, send_ok;
  logic [7:0] err_cnt;
  logic [5:0] pulses;
  logic [5:0] seen;
  int n_chk = 0;
  int n_bad = 0;

  // event bits for cyc()
  localparam logic [7:0] E_REQ = 8'h01, E_SBEG = 8'h02, E_SEND = 8'h04, E_STX = 8'h08;
  localparam logic [7:0] E_TXE = 8'h10, E_ACK = 8'h20, E_NAK = 8'h40, E_RXE = 8'h80;
  // pulse bits
  localparam logic [5:0] P_POLL = 6'h01, P_STX = 6'h02, P_ACK = 6'h04;
  localparam logic [5:0] P_OK = 6'h08, P_RETRY = 6'h10, P_SEND = 6'h20;

  always #4 clk = ~clk;

  assign pulses = {send_ok, retry_req, ack_ok, to_ack, to_stx, to_poll};

  hs_timeout_sup dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .req_low(req_low),
    .status_begin(status_begin), .status_end(status_end), .stx_seen(stx_seen),
    .tx_end(tx_end), .ack_seen(ack_seen), .nak_seen(nak_seen), .rx_end(rx_end),
    .to_poll(to_poll), .to_stx(to_stx), .to_ack(to_ack), .ack_ok(ack_ok),
    .retry_req(retry_req), .send_ok(send_ok), .err_cnt(err_cnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] ev, input logic tk);
    @(negedge clk);
    {rx_end, nak_seen, ack_seen, tx_end, stx_seen, status_end, status_begin, req_low} = ev;
    tick_1ms = tk;
    @(posedge clk);
    #1;
    seen = seen | pulses;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(8'h00, 1'b1);
  endtask

  task automatic t_reset;
    chk("R9 pulses after reset", int'(pulses), 0);
    chk("R9 err_cnt after reset", int'(err_cnt), 0);
  endtask

  task automatic t_poll_timeout;
    seen = '0;
    cyc(E_REQ, 1'b0);
    ticks(19);
    chk("R1 no poll timeout before 20th tick", int'(seen), 0);
    cyc(8'h00, 1'b1);
    chk("R1 poll timeout on 20th tick", int'(pulses), int'(P_POLL));
    cyc(8'h00, 1'b0);
    chk("R10 poll pulse lasts one cycle", int'(pulses), 0);
  endtask

  task automatic t_status_stx_timeout;
    seen = '0;
    cyc(E_REQ, 1'b0);
    ticks(19);
    cyc(E_SBEG, 1'b1);
    chk("R6 status start on expiring tick wins", int'(pulses), 0);
    ticks(40);
    chk("R2 timer frozen while status in flight", int'(seen), 0);
    cyc(E_SEND, 1'b0);
    ticks(199);
    chk("R2 no stx timeout before 200th tick", int'(seen), 0);
    cyc(8'h00, 1'b1);
    chk("R2 stx timeout on 200th tick", int'(pulses), int'(P_STX));
  endtask

  task automatic t_stx_arrives;
    seen = '0;
    cyc(E_REQ, 1'b0);
    cyc(E_SBEG, 1'b0);
    cyc(E_SEND, 1'b0);
    ticks(199);
    cyc(E_STX, 1'b1);
    chk("R6 stx on expiring tick wins", int'(pulses), 0);
    ticks(250);
    chk("R2 stx closes window silently", int'(seen), 0);
  endtask

  task automatic t_ack_timeout;
    seen = '0;
    cyc(E_TXE, 1'b0);
    ticks(39);
    chk("R3 no ack timeout before 40th tick", int'(seen), 0);
    cyc(8'h00, 1'b1);
    chk("R3 ack timeout on 40th tick", int'(pulses), int'(P_ACK));
  endtask

  task automatic t_ack_nak;
    cyc(E_TXE, 1'b0);
    ticks(10);
    cyc(E_ACK, 1'b0);
    chk("R4 ack gives ack_ok", int'(pulses), int'(P_OK));
    seen = '0;
    ticks(50);
    chk("R4 no timer after ack", int'(seen), 0);
    cyc(E_TXE, 1'b0);
    cyc(E_NAK, 1'b1);
    chk("R4 nak gives retry_req", int'(pulses), int'(P_RETRY));
    cyc(E_TXE, 1'b0);
    cyc(E_ACK | E_NAK, 1'b0);
    chk("R4 ack wins over nak", int'(pulses), int'(P_OK));
  endtask

  task automatic t_holdoff;
    seen = '0;
    cyc(E_RXE, 1'b0);
    ticks(4);
    chk("R5 no grant before 5th tick", int'(seen), 0);
    cyc(8'h00, 1'b1);
    chk("R5 send_ok on 5th tick", int'(pulses), int'(P_SEND));
  endtask

  task automatic t_idle_rules;
    seen = '0;
    cyc(E_ACK | E_NAK | E_STX | E_SBEG | E_SEND, 1'b0);
    ticks(60);
    chk("R8 stray events ignored in idle", int'(seen), 0);
    cyc(E_REQ | E_TXE | E_RXE, 1'b0);
    chk("R7 idle request not counted", int'(err_cnt), 0);
    ticks(19);
    chk("R8 request wins: no hold grant", int'(seen), 0);
    cyc(8'h00, 1'b1);
    chk("R8 request wins: poll timeout", int'(pulses), int'(P_POLL));
    seen = '0;
    cyc(E_TXE | E_RXE, 1'b0);
    ticks(39);
    chk("R8 tx_end wins over rx_end", int'(seen), 0);
    cyc(8'h00, 1'b1);
    chk("R8 tx_end wins: ack timeout", int'(pulses), int'(P_ACK));
  endtask

  task automatic t_err;
    seen = '0;
    cyc(E_REQ, 1'b0);
    ticks(3);
    cyc(E_REQ, 1'b1);
    chk("R7 busy request counted", int'(err_cnt), 1);
    ticks(15);
    chk("R7 busy request does not restart window", int'(seen), 0);
    cyc(8'h00, 1'b1);
    chk("R7 original window still expires", int'(pulses), int'(P_POLL));
    cyc(E_TXE, 1'b0);
    for (int i = 0; i < 300; i++) cyc(E_REQ, 1'b0);
    chk("R7 err_cnt saturates at 255", int'(err_cnt), 255);
    cyc(E_ACK, 1'b0);
    chk("R7 phase kept through busy requests", int'(pulses), int'(P_OK));
  endtask

  initial begin
    seen = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_poll_timeout();
    t_status_stx_timeout();
    t_stx_arrives();
    t_ack_timeout();
    t_ack_nak();
    t_holdoff();
    t_idle_rules();
    t_err();
    cyc(8'h00, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule